// File: doc/BRIEF.md
# Display Window Flush Sequencer

This block pushes one rectangular region of a frame to a display that takes commands. A clip rectangle arrives with exclusive end coordinates and a pulse on `start`. The block first sends the column window and then the row window. Each window is a command byte and four parameter bytes. After the windows it sends the memory-write command and then streams the pixel bytes of the region. Every byte leaves on a valid/ready byte port together with a flag that marks commands and data.

Pixels come from a valid/ready source. Each source word is either RGB565 in its low 16 bits or 32-bit XRGB, and the block packs XRGB down to RGB565 on the fly. A swap option reverses the order of the two bytes of each pixel. Per-panel column and row offsets are added to the window bounds before they are sent. A blank mode ignores the rectangle and the pixel source. It sets the window to the whole screen and writes zero pixels.

Top module: `win_flush_seq`

## Requirements
- R1: After an accepted start, the first five bytes are command 0x2A (dc=0) and then four parameter bytes (dc=1): start high, start low, end high, end low. Here start = x_lo + col_off and end = x_hi - 1 + col_off, both 16 bits.
- R2: The next five bytes are command 0x2B (dc=0) and then four parameter bytes in the same layout. Here start = y_lo + row_off and end = y_hi - 1 + row_off.
- R3: Byte 10 is command 0x2C (dc=0). It is followed by exactly (x_hi - x_lo) × (y_hi - y_lo) × 2 data bytes with dc=1, and then nothing more.
- R4: With fmt_xrgb=0 and swap=0, each pixel sends bits [15:8] of its source word and then bits [7:0].
- R5: With fmt_xrgb=1, each pixel is packed as {src[23:19], src[15:10], src[7:3]}, bits 15 down to 0.
- R6: With swap=1, the low byte of each packed pixel is sent before its high byte.
- R7: With blank=1, the windows are 0..SCR_W-1 and 0..SCR_H-1, each plus its offset. There are SCR_W × SCR_H × 2 zero data bytes, and pix_ready stays low for the whole flush.
- R8: A byte offered while out_ready is low stays unchanged until it is accepted. pix_ready is high only together with out_ready. Exactly one source word is taken for each two data bytes.
- R9: done is high for one cycle, in the cycle after the last byte is accepted. busy is low in the cycle after that. A start while busy is ignored.
- R10: During and after reset (rst_n low), out_valid, pix_ready, busy and done are low, and a reset in the middle of a flush abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a flush (taken while idle) |
| blank | input | 1 | Full-screen zero fill instead of the rectangle |
| fmt_xrgb | input | 1 | 1: source words are XRGB, 0: RGB565 |
| swap | input | 1 | Send the low pixel byte first |
| x_lo | input | COORD_W | First column of the rectangle |
| y_lo | input | COORD_W | First row of the rectangle |
| x_hi | input | COORD_W | Column end, exclusive |
| y_hi | input | COORD_W | Row end, exclusive |
| col_off | input | COORD_W | Panel column offset |
| row_off | input | COORD_W | Panel row offset |
| pix_valid | input | 1 | Source word valid |
| pix_ready | output | 1 | Source word taken |
| pix_data | input | 32 | Source word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_dc | output | 1 | 0: command byte, 1: parameter or pixel byte |
| busy | output | 1 | Flush in progress |
| done | output | 1 | One-cycle end-of-flush pulse |

## Verification
The assertions check the properties that hold in every cycle. Command bytes must carry one of the three command codes. A stalled byte must stay stable. pix_ready must only appear with out_ready. done must be one cycle long and must be followed by idle, and the idle block must be quiet. The bench scenarios are the only place where the window arithmetic is shown correct, including offsets that carry into the high byte. The same holds for the exact byte count, the XRGB packing, the swap order and the blank fill. Each of these is compared byte by byte against values the bench derives from the rectangle and its own pixel pattern.

// File: rtl/wfs_pkg.sv
// Shared definitions for the window flush sequencer.
// Assumes an 11-byte header: two window commands with four bytes each, then the write command.
package wfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PIX,
        ST_DONE
    } wfs_state_e;

    localparam logic [7:0] CMD_COL_WIN  = 8'h2A;
    localparam logic [7:0] CMD_ROW_WIN  = 8'h2B;
    localparam logic [7:0] CMD_MEM_WR   = 8'h2C;
    localparam int         HDR_BYTES    = 11;
    localparam int         HDR_IDX_W    = $clog2(HDR_BYTES);
endpackage

// File: rtl/wfs_hdr_mux.sv
// Selects the header byte for a given position: column command and bounds,
// row command and bounds, then the memory-write command.
// Assumes bounds fit in 16 bits; wider values are truncated to 16 bits.
module wfs_hdr_mux
    import wfs_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic [HDR_IDX_W-1:0] idx,
    input  logic [COORD_W-1:0]   col_first,
    input  logic [COORD_W-1:0]   col_last,
    input  logic [COORD_W-1:0]   row_first,
    input  logic [COORD_W-1:0]   row_last,
    output logic [7:0]           hdr_byte,
    output logic                 hdr_is_cmd
);
    logic [15:0] cf, cl, rf, rl;

    // widen the bounds to a fixed 16-bit field
    always_comb begin
        cf = 16'(col_first);
        cl = 16'(col_last);
        rf = 16'(row_first);
        rl = 16'(row_last);
    end

    // pick the byte for this header position
    always_comb begin
        hdr_is_cmd = 1'b0;
        case (idx)
            4'd0:    begin hdr_byte = CMD_COL_WIN; hdr_is_cmd = 1'b1; end
            4'd1:    hdr_byte = cf[15:8];
            4'd2:    hdr_byte = cf[7:0];
            4'd3:    hdr_byte = cl[15:8];
            4'd4:    hdr_byte = cl[7:0];
            4'd5:    begin hdr_byte = CMD_ROW_WIN; hdr_is_cmd = 1'b1; end
            4'd6:    hdr_byte = rf[15:8];
            4'd7:    hdr_byte = rf[7:0];
            4'd8:    hdr_byte = rl[15:8];
            4'd9:    hdr_byte = rl[7:0];
            default: begin hdr_byte = CMD_MEM_WR; hdr_is_cmd = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wfs_pix_pack.sv
// Packs a source word into RGB565 and orders its two bytes.
// Assumes XRGB keeps red in [23:16], green in [15:8] and blue in [7:0].
module wfs_pix_pack (
    input  logic [31:0] src,
    input  logic        fmt_xrgb,
    input  logic        swap,
    output logic [7:0]  first_byte,
    output logic [7:0]  second_byte
);
    logic [15:0] packed565;
    logic        unused_bits;

    // reduce XRGB to 5/6/5 or pass RGB565 through
    always_comb begin
        if (fmt_xrgb)
            packed565 = {src[23:19], src[15:10], src[7:3]};
        else
            packed565 = src[15:0];
    end

    // order the bytes: high first unless swapped
    always_comb begin
        first_byte  = swap ? packed565[7:0]  : packed565[15:8];
        second_byte = swap ? packed565[15:8] : packed565[7:0];
    end

    assign unused_bits = ^{src[31:24], src[18:16], src[9:8], src[2:0]};
endmodule

// File: rtl/win_flush_seq.sv
// Window flush sequencer: sends the column and row window commands, the
// memory-write command, then the region's pixels as RGB565 byte pairs.
// Assumes a nonempty rectangle (an empty one sends the header only) and a
// pixel source that holds its word while pix_valid is high and unaccepted.
module win_flush_seq
    import wfs_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int SCR_W   = 240,
    parameter int SCR_H   = 320
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               blank,
    input  logic               fmt_xrgb,
    input  logic               swap,
    input  logic [COORD_W-1:0] x_lo,
    input  logic [COORD_W-1:0] y_lo,
    input  logic [COORD_W-1:0] x_hi,
    input  logic [COORD_W-1:0] y_hi,
    input  logic [COORD_W-1:0] col_off,
    input  logic [COORD_W-1:0] row_off,
    input  logic               pix_valid,
    output logic               pix_ready,
    input  logic [31:0]        pix_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_dc,
    output logic               busy,
    output logic               done
);
    localparam int CNT_W = 2 * COORD_W;
    localparam logic [CNT_W-1:0]   SCR_PIX  = CNT_W'(SCR_W * SCR_H);
    localparam logic [COORD_W-1:0] SCR_XEND = COORD_W'(SCR_W - 1);
    localparam logic [COORD_W-1:0] SCR_YEND = COORD_W'(SCR_H - 1);
    localparam logic [HDR_IDX_W-1:0] HDR_LAST = HDR_IDX_W'(HDR_BYTES - 1);

    wfs_state_e           state;
    logic [HDR_IDX_W-1:0] hdr_idx;
    logic                 phase;
    logic [CNT_W-1:0]     pix_left;
    logic [7:0]           second_q;
    logic                 blank_q, fmt_q, swap_q;
    logic [COORD_W-1:0]   col_first, col_last, row_first, row_last;
    logic [COORD_W-1:0]   width, height;
    logic [7:0]           hdr_byte, first_b, second_b;
    logic                 hdr_is_cmd, beat;

    wfs_hdr_mux #(.COORD_W(COORD_W)) u_hdr (
        .idx        (hdr_idx),
        .col_first  (col_first),
        .col_last   (col_last),
        .row_first  (row_first),
        .row_last   (row_last),
        .hdr_byte   (hdr_byte),
        .hdr_is_cmd (hdr_is_cmd)
    );

    wfs_pix_pack u_pack (
        .src         (pix_data),
        .fmt_xrgb    (fmt_q),
        .swap        (swap_q),
        .first_byte  (first_b),
        .second_byte (second_b)
    );

    // rectangle size from the exclusive ends
    always_comb begin
        width  = x_hi - x_lo;
        height = y_hi - y_lo;
    end

    // drive the byte port and the pixel handshake from the state
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_dc    = 1'b1;
        pix_ready = 1'b0;
        case (state)
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_byte;
                out_dc    = ~hdr_is_cmd;
            end
            ST_PIX: begin
                if (!phase) begin
                    out_valid = blank_q | pix_valid;
                    out_data  = blank_q ? 8'h00 : first_b;
                    pix_ready = ~blank_q & out_ready;
                end else begin
                    out_valid = 1'b1;
                    out_data  = second_q;
                end
            end
            default: ;
        endcase
        beat = out_valid & out_ready;
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    // sequence the header, the pixel pairs and the end pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hdr_idx  <= '0;
            phase    <= 1'b0;
            pix_left <= '0;
            second_q <= 8'h00;
            blank_q  <= 1'b0;
            fmt_q    <= 1'b0;
            swap_q   <= 1'b0;
            col_first <= '0;
            col_last  <= '0;
            row_first <= '0;
            row_last  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_HDR;
                    hdr_idx <= '0;
                    phase   <= 1'b0;
                    blank_q <= blank;
                    fmt_q   <= fmt_xrgb;
                    swap_q  <= swap;
                    if (blank) begin
                        col_first <= col_off;
                        col_last  <= SCR_XEND + col_off;
                        row_first <= row_off;
                        row_last  <= SCR_YEND + row_off;
                        pix_left  <= SCR_PIX;
                    end else begin
                        col_first <= x_lo + col_off;
                        col_last  <= x_hi - 1'b1 + col_off;
                        row_first <= y_lo + row_off;
                        row_last  <= y_hi - 1'b1 + row_off;
                        pix_left  <= CNT_W'(width) * CNT_W'(height);
                    end
                end
                ST_HDR: if (beat) begin
                    if (hdr_idx == HDR_LAST)
                        state <= (pix_left == '0) ? ST_DONE : ST_PIX;
                    else
                        hdr_idx <= hdr_idx + 1'b1;
                end
                ST_PIX: if (beat) begin
                    if (!phase) begin
                        second_q <= blank_q ? 8'h00 : second_b;
                        phase    <= 1'b1;
                    end else begin
                        phase    <= 1'b0;
                        pix_left <= pix_left - 1'b1;
                        if (pix_left == CNT_W'(1))
                            state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wfs_chk.sv
// Cycle-level properties of the flush sequencer's ports.
// Assumes the pixel source holds its word while it waits.
module wfs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_dc,
    input logic       pix_ready,
    input logic       busy,
    input logic       done
);
    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dc) |-> (out_data == 8'h2A || out_data == 8'h2B || out_data == 8'h2C)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dc))); // R8
    AST_PIX_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> out_ready); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !pix_ready)); // R10
endmodule

bind win_flush_seq wfs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_dc    (out_dc),
    .pix_ready (pix_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/win_flush_seq_tb.sv
module win_flush_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int SH = 6;

    typedef struct packed {
        logic [15:0] x1, y1, x2, y2, lo, to;
        logic        fmt, swp, blk;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'd1, 16'd2, 16'd4, 16'd4, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{16'd0, 16'd0, 16'd3, 16'd1, 16'h0100, 16'h0200, 1'b0, 1'b1, 1'b0},
        '{16'd2, 16'd1, 16'd4, 16'd3, 16'd5,    16'd7,    1'b1, 1'b0, 1'b0},
        '{16'd0, 16'd0, 16'd2, 16'd2, 16'h00FF, 16'h0000, 1'b1, 1'b1, 1'b0},
        '{16'd9, 16'd9, 16'd9, 16'd9, 16'd3,    16'd1,    1'b0, 1'b0, 1'b1},
        '{16'd5, 16'd3, 16'd6, 16'd4, 16'hFFF0, 16'h00FE, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, blank = 1'b0, fmt_xrgb = 1'b0, swap = 1'b0;
    logic [15:0] x_lo = '0, y_lo = '0, x_hi = '0, y_hi = '0, col_off = '0, row_off = '0;
    logic pix_valid = 1'b1;
    logic pix_ready;
    logic [31:0] pix_data = '0;
    logic out_valid, out_dc, busy, done;
    logic out_ready = 1'b0;
    logic [7:0] out_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_flush_seq #(.COORD_W(16), .SCR_W(SW), .SCR_H(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blank(blank),
        .fmt_xrgb(fmt_xrgb), .swap(swap), .x_lo(x_lo), .y_lo(y_lo),
        .x_hi(x_hi), .y_hi(y_hi), .col_off(col_off), .row_off(row_off),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_dc(out_dc), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gen(input int p);
        return (32'(p) * 32'h0107_0B3D) ^ 32'h5AC3_81F5;
    endfunction

    function automatic logic [7:0] exp_byte(input vec_t v, input int n);
        logic [15:0] xs, xe, ys, ye, px;
        logic [31:0] g;
        if (v.blk) begin
            xs = v.lo; xe = 16'(SW - 1) + v.lo;
            ys = v.to; ye = 16'(SH - 1) + v.to;
        end else begin
            xs = v.x1 + v.lo; xe = v.x2 - 16'd1 + v.lo;
            ys = v.y1 + v.to; ye = v.y2 - 16'd1 + v.to;
        end
        case (n)
            0:  return 8'h2A;
            1:  return xs[15:8];
            2:  return xs[7:0];
            3:  return xe[15:8];
            4:  return xe[7:0];
            5:  return 8'h2B;
            6:  return ys[15:8];
            7:  return ys[7:0];
            8:  return ye[15:8];
            9:  return ye[7:0];
            10: return 8'h2C;
            default: begin
                if (v.blk) return 8'h00;
                g  = gen((n - 11) / 2);
                px = v.fmt ? {g[23:19], g[15:10], g[7:3]} : g[15:0];
                if (((n - 11) % 2 == 0) ^ v.swp) return px[15:8];
                return px[7:0];
            end
        endcase
    endfunction

    function automatic string tag_of(input vec_t v, input int n);
        if (n < 5)  return "R1";
        if (n < 10) return "R2";
        if (n == 10) return "R3";
        if (v.blk) return "R7";
        if (v.swp) return "R6";
        if (v.fmt) return "R5";
        return "R4";
    endfunction

    task automatic run_flush(input vec_t v, input bit mid_start);
        int npix, nbytes, n, k;
        npix   = v.blk ? SW * SH : int'(v.x2 - v.x1) * int'(v.y2 - v.y1);
        nbytes = 11 + 2 * npix;
        @(negedge clk);
        x_lo = v.x1; y_lo = v.y1; x_hi = v.x2; y_hi = v.y2;
        col_off = v.lo; row_off = v.to;
        fmt_xrgb = v.fmt; swap = v.swp; blank = v.blk;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; k = 0;
        while (n < nbytes) begin
            cyc++;
            out_ready = (cyc % 3 != 1);
            pix_data  = gen(k);
            if (mid_start && n >= 3 && n < 6) begin
                start = 1'b1; x_lo = 16'd0; x_hi = 16'd7; blank = 1'b1;
            end else begin
                start = 1'b0;
            end
            #1;
            if (v.blk && pix_ready) check(1'b0, "R7 pix_ready in blank", 32'(pix_ready), 32'd0);
            if (out_valid && out_ready) begin
                check(out_data == exp_byte(v, n), tag_of(v, n), 32'(out_data), 32'(exp_byte(v, n)));
                check(out_dc == !(n == 0 || n == 5 || n == 10), "R3 dc flag", 32'(out_dc),
                      32'(!(n == 0 || n == 5 || n == 10)));
                n++;
            end
            if (pix_ready && pix_valid) k++;
            @(negedge clk);
        end
        start = 1'b0;
        check(k == (v.blk ? 0 : npix), "R8 words consumed", 32'(k), 32'(v.blk ? 0 : npix));
        #1;
        check(done == 1'b1, "R9 done after last byte", 32'(done), 32'd1);
        check(out_valid == 1'b0, "R3 no extra byte", 32'(out_valid), 32'd0);
        @(negedge clk); #1;
        check(done == 1'b0 && busy == 1'b0, "R9 single pulse then idle", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // reset state, R10
        repeat (3) @(negedge clk);
        #1;
        check({out_valid, pix_ready, busy, done} == 4'b0, "R10 reset outputs",
              {28'd0, out_valid, pix_ready, busy, done}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // table of vectors walked by one loop
        for (int i = 0; i < NV; i++) run_flush(VECS[i], 1'b0);
        // start while busy is ignored, R9
        run_flush(VECS[2], 1'b1);
        // reset mid-flush abandons the transfer, R10
        @(negedge clk);
        x_lo = 16'd0; y_lo = 16'd0; x_hi = 16'd4; y_hi = 16'd4; blank = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        check({out_valid, pix_ready, busy, done} == 4'b0, "R10 mid-flush reset",
              {28'd0, out_valid, pix_ready, busy, done}, 32'd0);
        rst_n = 1'b1;
        run_flush(VECS[5], 1'b0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule